// File: doc/BRIEF.md
# Compact 16-bit Multicycle Processor Core

This block is a small 16-bit processor that takes several clock cycles per instruction. It has eight general registers of 16 bits. It holds the instruction register, the program counter, a latch for the ALU result and a latch for memory read data. It also contains the operand selectors, a five-function ALU that produces a zero indication, an immediate extender and the sequencer that steps each instruction through its phases. One external memory port serves both instruction fetch and data access. The port is combinational: read data is expected in the same cycle as the address. An address-source selector chooses between the program counter and the result path.

Every instruction is 16 bits wide and its fields never move. funct3 is [15:13], a 5-bit field is [12:8], register field X is [7:5], a 3-bit field Y is [4:2], and the major opcode is [1:0]. The instruction set covers five register-register ALU operations, an add-immediate, an absolute load, an absolute store and a branch-if-not-zero to an absolute target. Addresses are byte addresses and instructions are word aligned, so the program counter advances by 2.

Top module: `cpu16_core`

## Requirements
- R1: A synchronous reset, active low, clears the program counter, every register and the zero flag, and puts the sequencer in the fetch phase. During reset and in the first cycle after it, mem_addr is 0x0000 and mem_we is 0.
- R2: Every instruction costs one fetch cycle and one decode cycle plus its execution cycles. In total a branch takes 3 cycles, a register op, an add-immediate or a store take 4 cycles, and a load takes 5 cycles. Each fetch advances the program counter by 2.
- R3: Opcode 00 computes X <- X op Y, with X the register in [7:5] and Y the register in [4:2]. funct3 selects the operation: 000 is add, 001 is subtract (X minus Y), 010 is AND and 011 is OR. Add and subtract wrap modulo 2^16.
- R4: Opcode 00 with funct3 101 writes 16'h0001 to X when X is less than Y as signed two's-complement values, and 16'h0000 otherwise.
- R5: Opcode 01 with funct3 000 adds an 8-bit immediate {[12:8],[4:2]} to register X, after sign-extending the immediate to 16 bits.
- R6: Opcode 10 with funct3 000 loads register X from the word at the byte address {[12:8],[4:2]}. That address is zero-extended, so data lies in 0x00..0xFF.
- R7: Opcode 10 with funct3 001 stores register X to the word at the same zero-extended 8-bit address.
- R8: Opcode 11 forms an 11-bit target {[7:5],[12:8],[4:2]} and zero-extends it. It loads the target into the program counter only when the zero flag is 0, and otherwise continues in sequence. Only the results of opcode 00 and opcode 01 update the zero flag.
- R9: mem_we is high only in the write cycle of a store. Memory locations that no store addresses keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Byte address of the unified memory port |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Write enable for the addressed word |
| mem_rdata | input | 16 | Read data for mem_addr, valid in the same cycle |

## Verification
The branch cycle does two things at once. The ALU builds the absolute target, and the same cycle decides the branch from the zero flag that the previous add-immediate or register op left behind. The bench provokes both outcomes. A counted-down loop closes through an add-immediate of -1, so the branch is taken on every pass but the last. A subtract of a register from itself is followed by a branch that must fall through and perform a store. The outcome is judged against an instruction-level model built into the bench. The model predicts the final loop registers, whether the skipped store took place, and the total number of cycles.

// File: rtl/cpu16_pkg.sv
// cpu16_pkg: shared encodings for the compact 16-bit multicycle core.
// Assumes the fixed field layout described in the brief.
package cpu16_pkg;

    localparam int XLEN     = 16;
    localparam int NREGS    = 8;
    localparam int RIDX_W   = $clog2(NREGS);

    // Sequencer phases
    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_MEMADR = 4'd2,
        ST_MEMRD  = 4'd3,
        ST_MEMWB  = 4'd4,
        ST_MEMWR  = 4'd5,
        ST_EXR    = 4'd6,
        ST_ALUWB  = 4'd7,
        ST_EXI    = 4'd8,
        ST_BRANCH = 4'd9
    } cpu_state_e;

    // Operand A source
    typedef enum logic [1:0] {
        SA_PC   = 2'b00,
        SA_ZERO = 2'b01,
        SA_REG  = 2'b10
    } srca_e;

    // Operand B source
    typedef enum logic [1:0] {
        SB_REG = 2'b00,
        SB_IMM = 2'b01,
        SB_TWO = 2'b10
    } srcb_e;

    // Result path source
    typedef enum logic [1:0] {
        RS_ALUOUT = 2'b00,
        RS_DATA   = 2'b01,
        RS_ALU    = 2'b10
    } res_sel_e;

    // Immediate size / extension code
    typedef enum logic [1:0] {
        IMM_S8  = 2'b00,
        IMM_Z8  = 2'b01,
        IMM_S11 = 2'b10,
        IMM_Z11 = 2'b11
    } imm_sel_e;

    // ALU operation codes (equal to funct3)
    localparam logic [2:0] ALU_ADD = 3'b000;
    localparam logic [2:0] ALU_SUB = 3'b001;
    localparam logic [2:0] ALU_AND = 3'b010;
    localparam logic [2:0] ALU_OR  = 3'b011;
    localparam logic [2:0] ALU_SLT = 3'b101;

    // Major opcodes
    localparam logic [1:0] OP_REG  = 2'b00;
    localparam logic [1:0] OP_IMM  = 2'b01;
    localparam logic [1:0] OP_MEM  = 2'b10;
    localparam logic [1:0] OP_BNZ  = 2'b11;

    localparam logic [2:0] F3_LOAD  = 3'b000;
    localparam logic [2:0] F3_STORE = 3'b001;

endpackage

// File: rtl/cpu16_ctrl.sv
// cpu16_ctrl: Moore sequencer of the core. Steps fetch, decode and the
// per-format execute phases and drives the datapath selects.
// Assumes op/funct3 come from the instruction register, stable after fetch.
// An unknown funct3 under the memory opcode holds the address phase.
module cpu16_ctrl
    import cpu16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op,
    input  logic [2:0] funct3,
    output cpu_state_e state_o,
    output logic       pc_update,
    output logic       adr_src,
    output logic       mem_we,
    output logic       ir_we,
    output logic       reg_we,
    output logic       zero_en,
    output res_sel_e   res_sel,
    output srca_e      srca,
    output srcb_e      srcb,
    output imm_sel_e   imm_sel,
    output logic [2:0] alu_op
);

    cpu_state_e state_q;
    cpu_state_e state_d;

    // Phase register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Next-phase selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                case (op)
                    OP_REG:  state_d = ST_EXR;
                    OP_IMM:  state_d = ST_EXI;
                    OP_MEM:  state_d = ST_MEMADR;
                    default: state_d = ST_BRANCH;
                endcase
            end
            ST_MEMADR: begin
                if (funct3 == F3_LOAD)       state_d = ST_MEMRD;
                else if (funct3 == F3_STORE) state_d = ST_MEMWR;
                else                         state_d = ST_MEMADR;
            end
            ST_MEMRD:  state_d = ST_MEMWB;
            ST_EXR:    state_d = ST_ALUWB;
            ST_EXI:    state_d = ST_ALUWB;
            ST_MEMWB,
            ST_MEMWR,
            ST_ALUWB,
            ST_BRANCH: state_d = ST_FETCH;
            default:   state_d = ST_FETCH;
        endcase
    end

    // Per-phase datapath controls
    always_comb begin
        pc_update = 1'b0;
        adr_src   = 1'b0;
        mem_we    = 1'b0;
        ir_we     = 1'b0;
        reg_we    = 1'b0;
        zero_en   = 1'b0;
        res_sel   = RS_ALUOUT;
        srca      = SA_PC;
        srcb      = SB_REG;
        imm_sel   = IMM_S8;
        alu_op    = ALU_ADD;
        case (state_q)
            ST_FETCH: begin
                ir_we     = 1'b1;
                srcb      = SB_TWO;
                res_sel   = RS_ALU;
                pc_update = 1'b1;
            end
            ST_MEMADR: begin
                srca    = SA_ZERO;
                srcb    = SB_IMM;
                imm_sel = IMM_Z8;
            end
            ST_MEMRD: begin
                adr_src = 1'b1;
            end
            ST_MEMWB: begin
                res_sel = RS_DATA;
                reg_we  = 1'b1;
            end
            ST_MEMWR: begin
                adr_src = 1'b1;
                mem_we  = 1'b1;
            end
            ST_EXR: begin
                srca    = SA_REG;
                alu_op  = funct3;
                zero_en = 1'b1;
            end
            ST_EXI: begin
                srca    = SA_REG;
                srcb    = SB_IMM;
                alu_op  = funct3;
                zero_en = 1'b1;
            end
            ST_ALUWB: begin
                reg_we = 1'b1;
            end
            ST_BRANCH: begin
                srca    = SA_ZERO;
                srcb    = SB_IMM;
                imm_sel = IMM_Z11;
                res_sel = RS_ALU;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    AST_DECODE_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE)); // R2

    AST_LAST_PHASE_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALUWB || state_q == ST_MEMWB || state_q == ST_MEMWR ||
         state_q == ST_BRANCH) |=> (state_q == ST_FETCH)); // R2

    AST_LOAD_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEMRD) |=> (state_q == ST_MEMWB)); // R6

endmodule

// File: rtl/cpu16_regfile.sv
// cpu16_regfile: general register bank, two combinational read ports and
// one synchronous write port. All entries clear on reset.
module cpu16_regfile #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ra1,
    input  logic [AW-1:0]    ra2,
    output logic [WIDTH-1:0] rd1,
    output logic [WIDTH-1:0] rd2,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);

    logic [WIDTH-1:0] regs_q [DEPTH];

    // One register per entry, each with its own write decode
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                         regs_q[gi] <= '0;
            else if (we && (wa == AW'(gi)))     regs_q[gi] <= wd;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];

endmodule

// File: rtl/cpu16_alu.sv
// cpu16_alu: five-function ALU. The operation code equals funct3.
// Unlisted codes give zero. zero_o flags an all-zero result.
module cpu16_alu #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       op,
    output logic [WIDTH-1:0] y,
    output logic             zero_o
);
    import cpu16_pkg::*;

    // Operation select
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero_o = (y == '0);

endmodule

// File: rtl/cpu16_immext.sv
// cpu16_immext: builds the 8- or 11-bit immediate from the fixed fields and
// extends it to the data width. fld carries instruction bits [12:2].
// The 11-bit signed code is unused and yields zero.
module cpu16_immext #(
    parameter int WIDTH = 16
) (
    input  logic [10:0]      fld,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] imm
);
    import cpu16_pkg::*;

    logic [7:0]  imm8;
    logic [10:0] imm11;

    // Field gather: [12:8] high, [4:2] low, [7:5] on top for 11 bits
    assign imm8  = {fld[10:6], fld[2:0]};
    assign imm11 = {fld[5:3], imm8};

    // Size and extension select
    always_comb begin
        case (sel)
            IMM_S8:  imm = {{(WIDTH-8){imm8[7]}}, imm8};
            IMM_Z8:  imm = {{(WIDTH-8){1'b0}}, imm8};
            IMM_Z11: imm = {{(WIDTH-11){1'b0}}, imm11};
            default: imm = '0;
        endcase
    end

endmodule

// File: rtl/cpu16_core.sv
// cpu16_core: top of the compact multicycle core. Holds PC, IR, operand
// latches, ALU result and read data latches and the zero flag, and wires
// the sequencer, register bank, ALU and extender.
// Assumes mem_rdata answers mem_addr within the same cycle.
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        mem_we,
    input  logic [15:0] mem_rdata
);

    cpu_state_e state;
    logic       pc_update, adr_src, ir_we, reg_we, zero_en;
    res_sel_e   res_sel;
    srca_e      srca;
    srcb_e      srcb;
    imm_sel_e   imm_sel;
    logic [2:0] alu_op;

    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, aluout_q, data_q;
    logic            zero_q;
    logic [XLEN-1:0] rd1, rd2, imm, alu_a, alu_b, alu_y, result;
    logic            alu_zero, pc_write;

    cpu16_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (ir_q[1:0]),
        .funct3    (ir_q[15:13]),
        .state_o   (state),
        .pc_update (pc_update),
        .adr_src   (adr_src),
        .mem_we    (mem_we),
        .ir_we     (ir_we),
        .reg_we    (reg_we),
        .zero_en   (zero_en),
        .res_sel   (res_sel),
        .srca      (srca),
        .srcb      (srcb),
        .imm_sel   (imm_sel),
        .alu_op    (alu_op)
    );

    cpu16_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (ir_q[7:5]),
        .ra2   (ir_q[4:2]),
        .rd1   (rd1),
        .rd2   (rd2),
        .we    (reg_we),
        .wa    (ir_q[7:5]),
        .wd    (result)
    );

    cpu16_immext #(.WIDTH(XLEN)) u_imm (
        .fld (ir_q[12:2]),
        .sel (imm_sel),
        .imm (imm)
    );

    cpu16_alu #(.WIDTH(XLEN)) u_alu (
        .a      (alu_a),
        .b      (alu_b),
        .op     (alu_op),
        .y      (alu_y),
        .zero_o (alu_zero)
    );

    // Operand A select
    always_comb begin
        case (srca)
            SA_PC:   alu_a = pc_q;
            SA_REG:  alu_a = a_q;
            default: alu_a = '0;
        endcase
    end

    // Operand B select
    always_comb begin
        case (srcb)
            SB_REG:  alu_b = b_q;
            SB_IMM:  alu_b = imm;
            default: alu_b = XLEN'(2);
        endcase
    end

    // Result path select, feeds PC, register write data and address mux
    always_comb begin
        case (res_sel)
            RS_DATA: result = data_q;
            RS_ALU:  result = alu_y;
            default: result = aluout_q;
        endcase
    end

    // PC written on fetch, or on a branch whose flag is clear
    assign pc_write = pc_update | ((state == ST_BRANCH) & ~zero_q);

    assign mem_addr  = adr_src ? result : pc_q;
    assign mem_wdata = a_q;

    // Program counter and instruction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            if (pc_write) pc_q <= result;
            if (ir_we)    ir_q <= mem_rdata;
        end
    end

    // Free-running holding latches for operands, ALU result and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
            data_q   <= '0;
        end else begin
            a_q      <= rd1;
            b_q      <= rd2;
            aluout_q <= alu_y;
            data_q   <= mem_rdata;
        end
    end

    // Zero flag, captured with register-op and add-immediate results only
    always_ff @(posedge clk) begin
        if (!rst_n)       zero_q <= 1'b0;
        else if (zero_en) zero_q <= alu_zero;
    end

    AST_PC_STEP_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (pc_q == $past(pc_q) + 16'd2)); // R2

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRANCH && !zero_q) |=>
        (pc_q == {5'd0, $past(ir_q[7:5]), $past(ir_q[12:8]), $past(ir_q[4:2])})); // R8

    AST_BRANCH_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRANCH && zero_q) |=> (pc_q == $past(pc_q))); // R8

    AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (ir_q[1:0] == OP_MEM && ir_q[15:13] == F3_STORE && adr_src)); // R9

    AST_DATA_ADDR_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (adr_src && state != ST_FETCH) |-> (mem_addr[15:8] == 8'h00)); // R6

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EXR && state != ST_EXI) |=> $stable(zero_q)); // R8

endmodule

// File: tb/cpu16_core_tb.sv
// cpu16_core_tb: loads a generated program into a behavioural memory,
// runs it on the core and on an instruction-level model, then compares
// the data region, the store count and the total cycle count.
module cpu16_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    logic [15:0] mem     [0:1023];
    logic [15:0] ref_mem [0:1023];

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    cpu16_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[10:1]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[10:1]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [2:0] f3, input logic [4:0] mid,
                                        input logic [2:0] r, input logic [2:0] lo,
                                        input logic [1:0] op);
        return {f3, mid, r, lo, op};
    endfunction

    int pc_w;
    task automatic put(input logic [15:0] w);
        mem[pc_w[10:1]]     = w;
        ref_mem[pc_w[10:1]] = w;
        pc_w += 2;
    endtask
    task automatic put_data(input int a, input logic [15:0] w);
        mem[a/2]     = w;
        ref_mem[a/2] = w;
    endtask

    task automatic i_r(input logic [2:0] f, input logic [2:0] rd, input logic [2:0] rs);
        put(enc(f, 5'd0, rd, rs, 2'b00));
    endtask
    task automatic i_addi(input logic [2:0] rd, input logic [7:0] k);
        put(enc(3'b000, k[7:3], rd, k[2:0], 2'b01));
    endtask
    task automatic i_lw(input logic [2:0] rd, input logic [7:0] a);
        put(enc(3'b000, a[7:3], rd, a[2:0], 2'b10));
    endtask
    task automatic i_sw(input logic [2:0] rs, input logic [7:0] a);
        put(enc(3'b001, a[7:3], rs, a[2:0], 2'b10));
    endtask
    task automatic i_bnz(input logic [10:0] t);
        put(enc(3'b000, t[7:3], t[10:8], t[2:0], 2'b11));
    endtask

    // Reference ALU from R3/R4
    function automatic logic [15:0] ref_alu(input logic [2:0] f, input logic [15:0] a,
                                            input logic [15:0] b);
        case (f)
            3'b000:  return a + b;
            3'b001:  return a - b;
            3'b010:  return a & b;
            3'b011:  return a | b;
            3'b101:  return ($signed(a) < $signed(b)) ? 16'h0001 : 16'h0000;
            default: return 16'h0000;
        endcase
    endfunction

    // Requirement that owns a data-region word
    function automatic string tag_of(input int a);
        if (a >= 'h40 && a < 'h80) return "R3";
        if (a >= 'h80 && a < 'h90) return "R4";
        if (a >= 'h90 && a < 'hA0) return "R5";
        if (a >= 'hA0 && a < 'hB0) return "R8";
        if (a >= 'hB0 && a < 'hC0) return "R7";
        if (a == 'hFE)             return "R7";
        if (a >= 'h02 && a < 'h30) return "R6";
        return "R9";
    endfunction

    int ref_cycles, ref_stores;
    task automatic run_ref();
        logic [15:0] rr [8];
        logic [15:0] pc, ins;
        logic [7:0]  a8;
        logic        zf;
        bit          fin;
        for (int i = 0; i < 8; i++) rr[i] = '0;
        pc = '0; zf = 1'b0; fin = 0;
        ref_cycles = 0; ref_stores = 0;
        for (int step = 0; step < 20000 && !fin; step++) begin
            ins = ref_mem[pc[10:1]];
            pc  = pc + 16'd2;
            a8  = {ins[12:8], ins[4:2]};
            case (ins[1:0])
                2'b00: begin
                    rr[ins[7:5]] = ref_alu(ins[15:13], rr[ins[7:5]], rr[ins[4:2]]);
                    zf = (rr[ins[7:5]] == 16'h0);
                    ref_cycles += 4;
                end
                2'b01: begin
                    rr[ins[7:5]] = rr[ins[7:5]] + {{8{a8[7]}}, a8};
                    zf = (rr[ins[7:5]] == 16'h0);
                    ref_cycles += 4;
                end
                2'b10: begin
                    if (ins[15:13] == 3'b000) begin
                        rr[ins[7:5]] = ref_mem[a8[7:1]];
                        ref_cycles += 5;
                    end else begin
                        ref_mem[a8[7:1]] = rr[ins[7:5]];
                        ref_cycles += 4;
                        ref_stores++;
                        if (a8 == 8'hFE) fin = 1;
                    end
                end
                default: begin
                    if (!zf) pc = {5'd0, ins[7:5], a8};
                    ref_cycles += 3;
                end
            endcase
        end
    endtask

    logic [15:0] opa [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                             16'hFFFF, 16'h1234, 16'h8000, 16'h00F0};
    logic [15:0] opb [8] = '{16'h0000, 16'h0001, 16'h0001, 16'h0001,
                             16'h0001, 16'hFFFF, 16'h7FFF, 16'h0FF0};
    logic [2:0]  fns [5] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b101};
    logic [7:0]  imms[6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55};

    task automatic build();
        int lp, tgt;
        for (int i = 0; i < 1024; i++) begin mem[i] = '0; ref_mem[i] = '0; end
        for (int p = 0; p < 8; p++) begin
            put_data('h02 + 4*p, opa[p]);
            put_data('h04 + 4*p, opb[p]);
        end
        put_data('h22, 16'd5);
        put_data('h24, 16'h0010);
        put_data('h26, 16'h0101);
        put_data('h28, 16'h0001);
        pc_w = 0;
        i_bnz(11'h100);                 // zero flag clear after reset: taken
        pc_w = 'h100;
        // R3/R4: every operation over every operand pair
        for (int o = 0; o < 5; o++)
            for (int p = 0; p < 8; p++) begin
                i_lw(3'd1, 8'(('h02 + 4*p)));
                i_lw(3'd2, 8'(('h04 + 4*p)));
                i_r(fns[o], 3'd1, 3'd2);
                i_sw(3'd1, 8'(('h40 + 2*(o*8 + p))));
            end
        // R5: immediates across the sign boundary
        for (int k = 0; k < 6; k++) begin
            i_lw(3'd3, 8'h0A);
            i_addi(3'd3, imms[k]);
            i_sw(3'd3, 8'(('h90 + 2*k)));
        end
        // R8: counted loop closed by addi -1 and bneqz
        i_lw(3'd5, 8'h22);
        i_lw(3'd6, 8'h24);
        i_lw(3'd7, 8'h26);
        lp = pc_w;
        i_r(3'b000, 3'd6, 3'd7);
        i_addi(3'd5, 8'hFF);
        i_bnz(11'(lp));
        i_sw(3'd5, 8'hA0);
        i_sw(3'd6, 8'hA2);
        // R8: zero from a register op must fall through
        i_lw(3'd3, 8'h28);
        i_r(3'b001, 3'd1, 3'd1);
        tgt = pc_w + 4;
        i_bnz(11'(tgt));
        i_sw(3'd3, 8'hA4);
        // R6/R7: every register index through load and store
        for (int r = 0; r < 8; r++) i_lw(3'(r), 8'(('h02 + 2*r)));
        for (int r = 0; r < 8; r++) i_sw(3'(r), 8'(('hB0 + 2*r)));
        // completion marker and spin
        i_lw(3'd2, 8'h28);
        i_addi(3'd2, 8'h01);
        i_sw(3'd2, 8'hFE);
        i_bnz(11'(pc_w));
    endtask

    initial begin
        int  cyc, wr_cnt;
        bit  done;
        build();
        run_ref();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_we == 1'b0, "R1", "mem_we in reset", 16'(mem_we), 16'h0);
        chk(mem_addr == 16'h0, "R1", "mem_addr in reset", mem_addr, 16'h0);
        rst_n = 1'b1;
        cyc = 0; wr_cnt = 0; done = 0;
        while (!done && cyc < 20000) begin
            cyc++;
            #1;
            if (cyc == 1) begin
                chk(mem_addr == 16'h0, "R1", "first fetch address", mem_addr, 16'h0);
                chk(mem_we == 1'b0, "R1", "first cycle write", 16'(mem_we), 16'h0);
            end
            if (cyc == 4)
                chk(mem_addr == 16'h0100, "R8", "fetch after reset-time branch",
                    mem_addr, 16'h0100);
            if (mem_we) begin
                wr_cnt++;
                if (mem_addr == 16'h00FE) done = 1;
            end
            @(negedge clk);
        end
        if (!done) begin
            chk(1'b0, "R2", "watchdog expired", 16'(cyc), 16'(ref_cycles));
        end else begin
            chk(cyc == ref_cycles, "R2", "total cycles", 16'(cyc), 16'(ref_cycles));
            chk(wr_cnt == ref_stores, "R9", "write cycles", 16'(wr_cnt), 16'(ref_stores));
            @(posedge clk);
            #1;
            for (int i = 0; i < 128; i++)
                chk(mem[i] == ref_mem[i], tag_of(2*i), $sformatf("word %h", 2*i),
                    mem[i], ref_mem[i]);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule